// File: doc/BRIEF.md
# Channel Pair Skew Detector

This block measures how far apart in time three sliced video channels arrive. Each input is a single bit, already produced upstream by comparing one channel against a slice level. The channels are compared in a ring of three pairs: channel 0 against channel 1, channel 1 against channel 2, and channel 2 against channel 0. For each pair the block raises an up flag while the first signal of the pair is high and the second has not yet risen. It raises a down flag in the opposite case. The length of that flag in clock cycles is the skew between the two rising edges.

Each pair also keeps a signed accumulator. When a measurement is valid, the accumulator adds the measured skew, with the sign of the direction. A measurement is valid only if the lagging signal rises while the leading one is still high. A pulse that ends without overlap adds nothing and sets a sticky overrange flag for that pair. A synchronous clear empties all accumulators and overrange flags. Software or a control loop reads the accumulators to trim per-channel delays.

Top module: `skew_detector`

## Requirements
- R1: After reset all up flags, down flags and overrange flags are 0, and every accumulator reads 0.
- R2: Pair p compares channel p (the first signal) against channel (p+1) mod 3 (the second signal). Pair p's accumulator occupies bits [p*ACC_W +: ACC_W] of the accumulator bus, in two's complement.
- R3: If the first signal of a pair is sampled high, then the second is sampled high d cycles later, the up flag is high for exactly d cycles. It starts at the clock edge that samples the first rise.
- R4: If the second signal of a pair rises d cycles before the first, the down flag of that pair is high for exactly d cycles, with the same timing.
- R5: The up and down flags of a pair are never high in the same cycle.
- R6: A valid measurement adds +d (first signal led) or -d (second signal led) to the pair's accumulator. The addition happens at the edge that samples the lagging rise.
- R7: If both signals of a pair rise in the same cycle, no flag is raised and the accumulator does not change. The accumulator also never changes after a cycle in which the pair's flags were both low.
- R8: If the leading signal falls before, or in the same cycle as, the rise of the lagging one, the flag ends at the edge that samples the fall. The accumulator is unchanged. The pair's overrange flag is set and stays set until a clear.
- R9: A clear sampled high sets every accumulator and overrange flag to 0 at that edge. This holds even if a measurement completes at the same edge.
- R10: An accumulator saturates at its largest positive and most negative two's complement values instead of wrapping.
- R11: A skew longer than the in-flight counter limit (2^PEND_W - 1 cycles) contributes exactly that limit to the accumulator. The flag itself still lasts the full skew.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_i | input | NCH | Sliced channel bits, bit p is channel p |
| acc_clr_i | input | 1 | Synchronous clear of accumulators and overrange flags |
| up_o | output | NCH | Per pair: first signal leads, pulse in progress |
| dn_o | output | NCH | Per pair: second signal leads, pulse in progress |
| ovr_o | output | NCH | Per pair sticky overrange flag |
| acc_o | output | NCH*ACC_W | Per pair signed skew accumulators, pair p at [p*ACC_W +: ACC_W] |

## Verification
The only register between the inputs and the flags is the pair state. The flags therefore change at the same edge that samples the leading rise, and drop at the edge that samples the lagging rise or the leading fall. The accumulator and the overrange flag update at that final edge. The bench drives every input on a falling edge. Before it drives, it samples all outputs on that falling edge, so each sample reflects exactly the previous rising edge. It counts flag-high samples to measure pulse widths. It reads accumulators only a few idle cycles after a scenario ends, when they are settled. For a clear and a commit at the same edge, the clear is driven on the edge that also samples the lagging rise.

// File: rtl/skew_pkg.sv
`timescale 1ns/1ps
package skew_pkg;
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_LEAD_A = 2'd1,
        PS_LEAD_B = 2'd2
    } pair_st_e;
endpackage

// File: rtl/skew_edge.sv
`timescale 1ns/1ps
module skew_edge #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ch_i,
    output logic [NCH-1:0] rise_o
);
    typedef struct packed {
        logic [NCH-1:0] prev;
    } edge_reg_t;

    edge_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = ch_i;
        rise_o   = ch_i & ~r_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/skew_pair.sv
`timescale 1ns/1ps
module skew_pair
    import skew_pkg::*;
#(
    parameter int PEND_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_a_i,
    input  logic              lvl_b_i,
    input  logic              rise_a_i,
    input  logic              rise_b_i,
    output logic              up_o,
    output logic              dn_o,
    output logic              done_o,
    output logic              neg_o,
    output logic              bad_o,
    output logic [PEND_W-1:0] mag_o
);
    localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

    typedef struct packed {
        pair_st_e          st;
        logic [PEND_W-1:0] pend;
    } pair_reg_t;

    pair_reg_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        done_o = 1'b0;
        bad_o  = 1'b0;
        unique case (r_q.st)
            PS_IDLE: begin
                if (rise_a_i && !rise_b_i) begin
                    r_d.st   = PS_LEAD_A;
                    r_d.pend = PEND_ONE;
                end else if (rise_b_i && !rise_a_i) begin
                    r_d.st   = PS_LEAD_B;
                    r_d.pend = PEND_ONE;
                end
            end
            PS_LEAD_A: begin
                if (!lvl_a_i) begin
                    bad_o  = 1'b1;
                    r_d.st = PS_IDLE;
                end else if (rise_b_i) begin
                    done_o = 1'b1;
                    r_d.st = PS_IDLE;
                end else if (r_q.pend != '1) begin
                    r_d.pend = r_q.pend + PEND_ONE;
                end
            end
            PS_LEAD_B: begin
                if (!lvl_b_i) begin
                    bad_o  = 1'b1;
                    r_d.st = PS_IDLE;
                end else if (rise_a_i) begin
                    done_o = 1'b1;
                    r_d.st = PS_IDLE;
                end else if (r_q.pend != '1) begin
                    r_d.pend = r_q.pend + PEND_ONE;
                end
            end
            default: r_d.st = PS_IDLE;
        endcase
    end

    assign up_o  = (r_q.st == PS_LEAD_A);
    assign dn_o  = (r_q.st == PS_LEAD_B);
    assign neg_o = (r_q.st == PS_LEAD_B);
    assign mag_o = r_q.pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= PS_IDLE;
            r_q.pend <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/skew_acc.sv
`timescale 1ns/1ps
module skew_acc #(
    parameter int ACC_W  = 16,
    parameter int PEND_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              done_i,
    input  logic              neg_i,
    input  logic              bad_i,
    input  logic [PEND_W-1:0] mag_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              ovr_o
);
    localparam int EXT_W = ((ACC_W > PEND_W) ? ACC_W : PEND_W) + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovr;
    } acc_reg_t;

    acc_reg_t r_d, r_q;

    logic signed [EXT_W-1:0] cur, delta, sum, maxv, minv;

    always_comb begin
        r_d   = r_q;
        cur   = {{(EXT_W-ACC_W){r_q.acc[ACC_W-1]}}, r_q.acc};
        delta = {{(EXT_W-PEND_W){1'b0}}, mag_i};
        if (neg_i) delta = -delta;
        maxv  = {{(EXT_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
        minv  = -maxv - EXT_W'(1);
        sum   = cur + delta;
        if (sum > maxv)      sum = maxv;
        else if (sum < minv) sum = minv;

        if (clr_i) begin
            r_d.acc = '0;
            r_d.ovr = 1'b0;
        end else begin
            if (done_i) r_d.acc = sum[ACC_W-1:0];
            if (bad_i)  r_d.ovr = 1'b1;
        end
    end

    assign acc_o = r_q.acc;
    assign ovr_o = r_q.ovr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/skew_detector.sv
`timescale 1ns/1ps
module skew_detector #(
    parameter int NCH    = 3,
    parameter int ACC_W  = 16,
    parameter int PEND_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ch_i,
    input  logic                 acc_clr_i,
    output logic [NCH-1:0]       up_o,
    output logic [NCH-1:0]       dn_o,
    output logic [NCH-1:0]       ovr_o,
    output logic [NCH*ACC_W-1:0] acc_o
);
    logic [NCH-1:0] rise;

    skew_edge #(.NCH(NCH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ch_i   (ch_i),
        .rise_o (rise)
    );

    for (genvar p = 0; p < NCH; p++) begin : g_pair
        localparam int BI = (p + 1) % NCH;
        logic              done, neg, bad;
        logic [PEND_W-1:0] mag;

        skew_pair #(.PEND_W(PEND_W)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_a_i  (ch_i[p]),
            .lvl_b_i  (ch_i[BI]),
            .rise_a_i (rise[p]),
            .rise_b_i (rise[BI]),
            .up_o     (up_o[p]),
            .dn_o     (dn_o[p]),
            .done_o   (done),
            .neg_o    (neg),
            .bad_o    (bad),
            .mag_o    (mag)
        );

        skew_acc #(.ACC_W(ACC_W), .PEND_W(PEND_W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (acc_clr_i),
            .done_i (done),
            .neg_i  (neg),
            .bad_i  (bad),
            .mag_i  (mag),
            .acc_o  (acc_o[p*ACC_W +: ACC_W]),
            .ovr_o  (ovr_o[p])
        );
    end
endmodule

// File: rtl/skew_detector_chk.sv
`timescale 1ns/1ps
module skew_detector_chk #(
    parameter int NCH    = 3,
    parameter int ACC_W  = 16,
    parameter int PEND_W = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       ch_i,
    input logic                 acc_clr_i,
    input logic [NCH-1:0]       up_o,
    input logic [NCH-1:0]       dn_o,
    input logic [NCH-1:0]       ovr_o,
    input logic [NCH*ACC_W-1:0] acc_o
);
    // R5
    up_dn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o & dn_o) == '0);

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr_i |=> (acc_o == '0 && ovr_o == '0));

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_clr_i |=> ((ovr_o & $past(ovr_o)) == $past(ovr_o)));

    // R7
    quiet_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o == '0 && dn_o == '0 && !acc_clr_i) |=> $stable(acc_o));

    for (genvar p = 0; p < NCH; p++) begin : g_chk
        localparam int BI = (p + 1) % NCH;
        // R3
        up_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(up_o[p]) |-> $past(ch_i[p]));
        // R4
        dn_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dn_o[p]) |-> $past(ch_i[BI]));
    end
endmodule

bind skew_detector skew_detector_chk #(.NCH(NCH), .ACC_W(ACC_W), .PEND_W(PEND_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_i      (ch_i),
    .acc_clr_i (acc_clr_i),
    .up_o      (up_o),
    .dn_o      (dn_o),
    .ovr_o     (ovr_o),
    .acc_o     (acc_o)
);

// File: tb/sim_skew_detector.sv
`timescale 1ns/1ps
module sim_skew_detector;
    localparam int NCH    = 3;
    localparam int ACC_W  = 8;
    localparam int PEND_W = 6;
    localparam int NEVER  = 255;
    localparam int HOLD   = 40;
    localparam int NV     = 5;

    localparam int V_OFF [NV][NCH] = '{
        '{0, 3, 5}, '{7, 2, 2}, '{4, 4, 4}, '{1, NEVER, 10}, '{0, 12, 1}};
    localparam int V_ACC [NV][NCH] = '{
        '{3, 2, -5}, '{-5, 0, 5}, '{0, 0, 0}, '{0, 0, -9}, '{12, -11, -1}};
    localparam logic [NCH-1:0] V_OVR [NV] = '{3'b000, 3'b000, 3'b000, 3'b011, 3'b000};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCH-1:0]       ch_i = '0;
    logic                 acc_clr_i = 1'b0;
    logic [NCH-1:0]       up_o, dn_o, ovr_o;
    logic [NCH*ACC_W-1:0] acc_o;

    int n_chk = 0;
    int n_err = 0;
    int up_cnt [NCH];
    int dn_cnt [NCH];
    bit excl_bad;

    always #2.5 clk = ~clk;

    skew_detector #(.NCH(NCH), .ACC_W(ACC_W), .PEND_W(PEND_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_i(ch_i), .acc_clr_i(acc_clr_i),
        .up_o(up_o), .dn_o(dn_o), .ovr_o(ovr_o), .acc_o(acc_o));

    function automatic int acc_of(int p);
        logic signed [ACC_W-1:0] s;
        s = acc_o[p*ACC_W +: ACC_W];
        return int'(s);
    endfunction

    task automatic chk_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic sample();
        for (int p = 0; p < NCH; p++) begin
            if (up_o[p]) up_cnt[p]++;
            if (dn_o[p]) dn_cnt[p]++;
        end
        if ((up_o & dn_o) != '0) excl_bad = 1'b1;
    endtask

    // Channel c goes high for edges off[c] .. hold-1; clear driven at edge clr_at.
    task automatic run_scn(int o0, int o1, int o2, int hold, int clr_at);
        int off [NCH];
        off = '{o0, o1, o2};
        for (int p = 0; p < NCH; p++) begin up_cnt[p] = 0; dn_cnt[p] = 0; end
        excl_bad = 1'b0;
        for (int t = 0; t <= hold + 3; t++) begin
            @(negedge clk);
            sample();
            for (int c = 0; c < NCH; c++)
                ch_i[c] = (off[c] != NEVER) && (t >= off[c]) && (t < hold);
            acc_clr_i = (t == clr_at);
        end
        @(negedge clk);
        sample();
        acc_clr_i = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        acc_clr_i = 1'b1;
        @(negedge clk);
        acc_clr_i = 1'b0;
    endtask

    function automatic void exp_cnt(int oa, int ob, int hold, output int eu, output int ed);
        eu = 0; ed = 0;
        if (oa != NEVER && ob != NEVER) begin
            if (ob > oa) eu = ob - oa;
            else         ed = oa - ob;
        end else if (oa != NEVER) eu = hold - oa;
        else if (ob != NEVER)     ed = hold - ob;
    endfunction

    initial begin
        #100000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1", "up", int'(up_o), 0);
        chk_eq("R1", "dn", int'(dn_o), 0);
        chk_eq("R1", "ovr", int'(ovr_o), 0);
        for (int p = 0; p < NCH; p++) chk_eq("R1", "acc", acc_of(p), 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            do_clear();
            run_scn(V_OFF[v][0], V_OFF[v][1], V_OFF[v][2], HOLD, -1);
            for (int p = 0; p < NCH; p++) begin
                int eu, ed;
                exp_cnt(V_OFF[v][p], V_OFF[v][(p+1)%NCH], HOLD, eu, ed);
                chk_eq("R2/R6/R7", $sformatf("vec%0d pair%0d acc", v, p), acc_of(p), V_ACC[v][p]);
                chk_eq("R3", $sformatf("vec%0d pair%0d up width", v, p), up_cnt[p], eu);
                chk_eq("R4", $sformatf("vec%0d pair%0d dn width", v, p), dn_cnt[p], ed);
            end
            chk_eq("R8", $sformatf("vec%0d ovr", v), int'(ovr_o), int'(V_OVR[v]));
            chk_eq("R5", $sformatf("vec%0d up&dn overlap", v), int'(excl_bad), 0);
        end

        // R9: clear at the same edge as the commits
        do_clear();
        run_scn(0, 3, 3, 10, 3);
        for (int p = 0; p < NCH; p++) chk_eq("R9", "acc after clear-vs-commit", acc_of(p), 0);

        // R8 then R9: overrange flags set, then cleared
        run_scn(5, NEVER, NEVER, 10, -1);
        chk_eq("R8", "ovr set", int'(ovr_o), 5);
        run_scn(NEVER, NEVER, NEVER, 2, -1);
        chk_eq("R8", "ovr held", int'(ovr_o), 5);
        do_clear();
        chk_eq("R9", "ovr cleared", int'(ovr_o), 0);

        // R10 saturation both directions
        begin
            int exp_pos [4] = '{40, 80, 120, 127};
            int exp_neg [4] = '{-40, -80, -120, -128};
            for (int k = 0; k < 4; k++) begin
                run_scn(0, 40, 40, 50, -1);
                chk_eq("R10", $sformatf("pos step %0d", k), acc_of(0), exp_pos[k]);
                chk_eq("R10", $sformatf("neg step %0d", k), acc_of(2), exp_neg[k]);
            end
        end

        // R11 in-flight counter limit
        do_clear();
        run_scn(0, 70, 0, 80, -1);
        chk_eq("R11", "pair0 acc limited", acc_of(0), 63);
        chk_eq("R11", "pair1 acc limited", acc_of(1), -63);
        chk_eq("R3", "pair0 up width long", up_cnt[0], 70);
        chk_eq("R7", "pair2 simultaneous", acc_of(2), 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule